// File: doc/BRIEF.md
# Sub-word Lane Insert/Extract Unit

This unit works on one byte lane or one halfword lane of a 32-bit word. Software uses it to emulate sub-word memory traffic on a machine that only moves whole words. For a store, a loaded word goes in as the destination value and one lane of it is replaced by the low byte or low halfword of a source value. For a load, one lane of a loaded word is pulled down to the bottom of the result and sign-extended. The low bits of a position operand pick the lane, so a byte address can be passed in unchanged.

The extract operations also report on the bits that lie above the selected field. Carry is set when any of those bits is nonzero, which tests an unsigned range. Overflow is set when any of those bits differs from the field's sign bit, which tests a signed range. The insert operations pass the incoming flags through unchanged. The result and the flags are registered, and a valid strobe marks each accepted operation.

Top module: `lxu_top`

## Requirements
- R1: Opcode 4'b0111 returns the destination value with byte lane pos[1:0] (bits 8*pos+7 down to 8*pos) replaced by source bits 7:0. All other destination bits are kept.
- R2: Opcode 4'b0110 returns the destination value with halfword lane pos[1] (shift 0 or 16) replaced by source bits 15:0. pos[0] has no effect.
- R3: For both insert opcodes, the output flags equal the flags input presented with the operation.
- R4: Opcode 4'b0101 returns source byte lane pos[1:0], sign-extended to 32 bits.
- R5: Opcode 4'b0100 returns source halfword lane pos[1], sign-extended to 32 bits.
- R6: The flags are packed as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. For extract, N is result bit 31 and Z is set only when the 32-bit result is zero.
- R7: For extract, C is set when any bit of the source shifted right by the lane offset is nonzero above the field width (8 or 16).
- R8: For extract, V is set when any bit of the shifted source above the field width differs from the field's top bit. This includes the zeros shifted in from the top.
- R9: Position bits 31:2 have no effect on any result or flag.
- R10: The result and flags appear one clock after an opcode in 4'b0100 to 4'b0111 is presented, and valid_o is high for that one cycle.
- R11: Any other opcode holds result_o and flags_o at their previous values and drives valid_o low on the next cycle.
- R12: While rst_n is low, result_o, flags_o and valid_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| dst_i | input | 32 | Word to be merged into (insert) |
| src_i | input | 32 | Lane data (insert) or word to select from (extract) |
| pos_i | input | 32 | Position operand; the low bits pick the lane |
| flags_i | input | 4 | Incoming NZVC flags |
| result_o | output | 32 | Registered result |
| flags_o | output | 4 | Registered NZVC flags |
| valid_o | output | 1 | High for one cycle per accepted operation |

## Verification
Inserts are driven with distinct byte patterns in the destination and the source. A byte landing in the wrong lane, or a destination byte being lost, then gives a different word. Extracts are run on fields with the top bit clear and with the top bit set, and on upper bits that are all zero, all ones or mixed. This separates the C case from the V case, including the top lane, where only zeros are shifted in. Each pair of runs differs only in the ignored position bits or in pos[0] for halfwords. Runs of invalid opcodes between valid ones show whether the outputs hold and whether the strobe falls.

// File: rtl/lxu_pkg.sv
package lxu_pkg;

   typedef enum logic [3:0] {
      OP_EXT_HALF = 4'b0100,
      OP_EXT_BYTE = 4'b0101,
      OP_INS_HALF = 4'b0110,
      OP_INS_BYTE = 4'b0111
   } lxu_op_e;

   typedef struct packed {
      logic neg;
      logic zero;
      logic ovf;
      logic carry;
   } lxu_flags_t;

endpackage

// File: rtl/lxu_insert.sv
module lxu_insert #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic                          half_mode,
   input  logic [$clog2(DATA_W/BYTE_W)-1:0] lane_sel,
   input  logic [DATA_W-1:0]             dst_word,
   input  logic [2*BYTE_W-1:0]           src_low,
   output logic [DATA_W-1:0]             merged
);
   localparam int LANES    = DATA_W / BYTE_W;
   localparam int SEL_BITS = $clog2(LANES);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int HIDX = i / 2;
      localparam int PART = i % 2;
      logic             hit_byte;
      logic             hit_half;
      logic             hit;
      logic [BYTE_W-1:0] fill;

      assign hit_byte = (lane_sel == SEL_BITS'(i));
      assign hit_half = (lane_sel[SEL_BITS-1:1] == (SEL_BITS-1)'(HIDX));
      assign hit      = half_mode ? hit_half : hit_byte;
      assign fill     = half_mode ? src_low[PART*BYTE_W +: BYTE_W]
                                  : src_low[BYTE_W-1:0];
      assign merged[i*BYTE_W +: BYTE_W] = hit ? fill : dst_word[i*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/lxu_extract.sv
module lxu_extract
   import lxu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic                             half_mode,
   input  logic [$clog2(DATA_W/BYTE_W)-1:0] lane_sel,
   input  logic [DATA_W-1:0]                src_word,
   output logic [DATA_W-1:0]                ext_word,
   output lxu_flags_t                       ext_flags
);
   localparam int LANES    = DATA_W / BYTE_W;
   localparam int SEL_BITS = $clog2(LANES);
   localparam int LOG_BW   = $clog2(BYTE_W);
   localparam int SH_W     = $clog2(DATA_W);

   logic [DATA_W-1:0] cand_val [2];
   lxu_flags_t        cand_flg [2];

   // k = 0: byte field, k = 1: halfword field
   for (genvar k = 0; k < 2; k++) begin : g_width
      localparam int FW = BYTE_W << k;
      logic [SH_W-1:0]      sh;
      logic [DATA_W-1:0]    fld;
      logic [DATA_W-FW-1:0] upper;
      logic                 sgn;

      assign sh    = (SH_W'(lane_sel) >> k) << (k + LOG_BW);
      assign fld   = src_word >> sh;
      assign upper = fld[DATA_W-1:FW];
      assign sgn   = fld[FW-1];

      assign cand_val[k]       = {{(DATA_W-FW){sgn}}, fld[FW-1:0]};
      assign cand_flg[k].neg   = sgn;
      assign cand_flg[k].zero  = (fld[FW-1:0] == '0);
      assign cand_flg[k].carry = |upper;
      assign cand_flg[k].ovf   = |(upper ^ {(DATA_W-FW){sgn}});
   end

   assign ext_word  = half_mode ? cand_val[1] : cand_val[0];
   assign ext_flags = half_mode ? cand_flg[1] : cand_flg[0];

endmodule

// File: rtl/lxu_top.sv
module lxu_top
   import lxu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] pos_i,
   input  logic [3:0]        flags_i,
   output logic [DATA_W-1:0] result_o,
   output logic [3:0]        flags_o,
   output logic              valid_o
);
   localparam int LANES    = DATA_W / BYTE_W;
   localparam int SEL_BITS = $clog2(LANES);

   if (DATA_W % BYTE_W != 0) begin : g_chk_div
      $error("lxu_top: DATA_W must be a multiple of BYTE_W");
   end
   if (LANES < 4 || (1 << SEL_BITS) != LANES) begin : g_chk_lanes
      $error("lxu_top: lane count must be a power of two, at least 4");
   end
   if ((1 << $clog2(BYTE_W)) != BYTE_W) begin : g_chk_bw
      $error("lxu_top: BYTE_W must be a power of two");
   end

   logic [SEL_BITS-1:0] lane_sel;
   logic [DATA_W-1:0]   unused_pos_hi;
   logic                op_ok, is_ins, is_half;
   logic [DATA_W-1:0]   ins_word, ext_word, nxt_word;
   lxu_flags_t          ext_flags;
   logic [3:0]          nxt_flags;

   assign lane_sel      = pos_i[SEL_BITS-1:0];
   assign unused_pos_hi = pos_i;

   always_comb begin
      op_ok   = 1'b1;
      is_ins  = 1'b0;
      is_half = 1'b0;
      case (op_i)
         OP_EXT_HALF: is_half = 1'b1;
         OP_EXT_BYTE: ;
         OP_INS_HALF: begin is_ins = 1'b1; is_half = 1'b1; end
         OP_INS_BYTE: is_ins = 1'b1;
         default:     op_ok = 1'b0;
      endcase
   end

   lxu_insert #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ins (
      .half_mode (is_half),
      .lane_sel  (lane_sel),
      .dst_word  (dst_i),
      .src_low   (src_i[2*BYTE_W-1:0]),
      .merged    (ins_word)
   );

   lxu_extract #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext (
      .half_mode (is_half),
      .lane_sel  (lane_sel),
      .src_word  (src_i),
      .ext_word  (ext_word),
      .ext_flags (ext_flags)
   );

   assign nxt_word  = is_ins ? ins_word : ext_word;
   assign nxt_flags = is_ins ? flags_i : ext_flags;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o <= '0;
         flags_o  <= '0;
         valid_o  <= 1'b0;
      end else if (op_ok) begin
         result_o <= nxt_word;
         flags_o  <= nxt_flags;
         valid_o  <= 1'b1;
      end else begin
         valid_o  <= 1'b0;
      end
   end

   assert_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      op_ok |=> valid_o);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !op_ok |=> (!valid_o && $stable(result_o) && $stable(flags_o)));

   assert_ins_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_ok && is_ins) |=> (flags_o == $past(flags_i)));

   assert_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_EXT_BYTE) |=>
         (result_o[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){result_o[BYTE_W-1]}}));

   assert_nz_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_ok && !is_ins) |=>
         (flags_o[3] == result_o[DATA_W-1] && flags_o[2] == (result_o == '0)));

   assert_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_INS_BYTE && pos_i[SEL_BITS-1:0] == '0) |=>
         (result_o[DATA_W-1:BYTE_W] == $past(dst_i[DATA_W-1:BYTE_W]) &&
          result_o[BYTE_W-1:0] == $past(src_i[BYTE_W-1:0])));

endmodule

// File: tb/sim_lxu_top.sv
module sim_lxu_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = 4'h0;
   logic [31:0] dst = '0, src = '0, pos = '0;
   logic [3:0]  flg = '0;
   logic [31:0] result;
   logic [3:0]  flags;
   logic        valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   lxu_top u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op), .dst_i(dst), .src_i(src),
      .pos_i(pos), .flags_i(flg), .result_o(result), .flags_o(flags),
      .valid_o(valid)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] m_ins(input bit half, input logic [31:0] d,
                                         input logic [31:0] s, input logic [31:0] p);
      int sh;
      logic [31:0] m;
      sh = half ? 16 * int'(p[1]) : 8 * int'(p[1:0]);
      m  = half ? 32'hFFFF : 32'hFF;
      return (d & ~(m << sh)) | ((s & m) << sh);
   endfunction

   function automatic logic [35:0] m_ext(input bit half, input logic [31:0] s,
                                         input logic [31:0] p);
      int sh, w;
      logic [31:0] f, m, v, up, pat;
      logic sg, n, z, vf, c;
      w  = half ? 16 : 8;
      sh = half ? 16 * int'(p[1]) : 8 * int'(p[1:0]);
      m  = half ? 32'hFFFF : 32'hFF;
      f  = s >> sh;
      v  = f & m;
      sg = v[w-1];
      if (sg) v = v | ~m;
      up  = f >> w;
      pat = sg ? (32'hFFFF_FFFF >> w) : 32'h0;
      n  = v[31];
      z  = (v == 0);
      c  = (up != 0);
      vf = (up != pat);
      return {v, n, z, vf, c};
   endfunction

   task automatic drive(input logic [3:0] o, input logic [31:0] d, input logic [31:0] s,
                        input logic [31:0] p, input logic [3:0] f);
      @(negedge clk);
      op = o; dst = d; src = s; pos = p; flg = f;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R12 result", result, 32'h0);
      chk("R12 flags", {28'h0, flags}, 32'h0);
      chk("R12 valid", {31'h0, valid}, 32'h0);
   endtask

   task automatic t_ins_byte;
      for (int i = 0; i < 4; i++) begin
         drive(4'b0111, 32'hA1B2C3D4, 32'h5566_77E9 + i, i, 4'h0);
         chk($sformatf("R1 lane%0d", i), result, m_ins(0, 32'hA1B2C3D4, 32'h556677E9 + i, i));
      end
   endtask

   task automatic t_ins_half;
      for (int i = 0; i < 4; i++) begin
         drive(4'b0110, 32'h1122_3344, 32'hDEAD_BEEF, i, 4'h0);
         chk($sformatf("R2 pos%0d", i), result, m_ins(1, 32'h11223344, 32'hDEADBEEF, i));
      end
   endtask

   task automatic t_ins_flags;
      drive(4'b0111, 32'h0, 32'h0, 0, 4'b1010);
      chk("R3 byte flags", {28'h0, flags}, 32'hA);
      drive(4'b0110, 32'hFFFF_FFFF, 32'h8000_0000, 2, 4'b0101);
      chk("R3 half flags", {28'h0, flags}, 32'h5);
   endtask

   task automatic t_ext(input bit half, input logic [31:0] s, input logic [31:0] p, input string tag);
      logic [35:0] e;
      e = m_ext(half, s, p);
      drive(half ? 4'b0100 : 4'b0101, 32'h0, s, p, 4'h0);
      chk({tag, " R4/R5 value"}, result, e[35:4]);
      chk({tag, " R6 NZ"}, {30'h0, flags[3:2]}, {30'h0, e[3:2]});
      chk({tag, " R7 C"}, {31'h0, flags[0]}, {31'h0, e[0]});
      chk({tag, " R8 V"}, {31'h0, flags[1]}, {31'h0, e[1]});
   endtask

   task automatic t_ext_byte;
      t_ext(0, 32'h1234_5680, 0, "byte mixed");
      t_ext(0, 32'h80AB_CDEF, 3, "byte top neg");
      t_ext(0, 32'h7F00_0000, 3, "byte top pos");
      t_ext(0, 32'hFFFF_FF80, 0, "byte ones");
      t_ext(0, 32'h0000_0000, 1, "byte zero");
      chk("R4 neg value", result, 32'h0);
      t_ext(0, 32'h00FE_0000, 2, "byte lane2");
   endtask

   task automatic t_ext_half;
      t_ext(1, 32'hABCD_1234, 2, "half hi");
      t_ext(1, 32'h0000_7FFF, 0, "half lo pos");
      t_ext(1, 32'hFFFF_8001, 1, "half pos1");
      t_ext(1, 32'h0001_8000, 0, "half mixed");
   endtask

   task automatic t_pos_ignore;
      logic [31:0] r0;
      logic [3:0]  f0;
      drive(4'b0101, 32'h0, 32'hC3A5_5A3C, 32'h0000_0001, 4'h0);
      r0 = result; f0 = flags;
      drive(4'b0101, 32'h0, 32'hC3A5_5A3C, 32'hFFFF_FFFD, 4'h0);
      chk("R9 ext value", result, r0);
      chk("R9 ext flags", {28'h0, flags}, {28'h0, f0});
      drive(4'b0111, 32'h0102_0304, 32'h99, 32'h8000_0006, 4'h0);
      chk("R9 ins", result, 32'h0199_0304);
   endtask

   task automatic t_invalid;
      drive(4'b0101, 32'h0, 32'h0000_0080, 0, 4'h0);
      chk("R10 valid", {31'h0, valid}, 32'h1);
      drive(4'b0011, 32'h5555_5555, 32'h1234_5678, 1, 4'hF);
      chk("R11 valid low", {31'h0, valid}, 32'h0);
      chk("R11 result held", result, 32'hFFFF_FF80);
      chk("R11 flags held", {28'h0, flags}, 32'hA);
      drive(4'b1111, 32'h0, 32'h0, 0, 4'h0);
      chk("R11 held again", result, 32'hFFFF_FF80);
   endtask

   task automatic t_latency;
      @(negedge clk);
      op = 4'b0111; dst = 32'h0; src = 32'h42; pos = 0;
      @(posedge clk); #1;
      chk("R10 one cycle", result, 32'h42);
      chk("R10 strobe", {31'h0, valid}, 32'h1);
      @(negedge clk);
      op = 4'h0;
      @(negedge clk);
      chk("R10 strobe drop", {31'h0, valid}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_ins_byte();
      t_ins_half();
      t_ins_flags();
      t_ext_byte();
      t_ext_half();
      t_pos_ignore();
      t_invalid();
      t_latency();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule